// File: doc/BRIEF.md
# Configurable Serial Line Transmitter

This block turns parallel bytes into asynchronous serial frames on one output wire that rests high when nothing is sent. A byte offered on a valid/ready handshake is held in a one-entry holding stage. When the frame engine is free, it moves the byte into its shift stage and sends a low start bit. The data bits follow least significant bit first, then an optional parity bit, then the stop time at the high level. All timing comes from an internal tick enable that fires once every `divisor` clock cycles. One bit cell lasts sixteen ticks, so a stop time of one and a half bits is exactly twenty-four ticks.

A 7-bit line-control input sets the frame shape. It selects a word length of 5 to 8 bits, one of five parity modes and the stop length. A break bit holds the line low. The frame engine is a five-state machine: `ST_IDLE`, `ST_START`, `ST_DATA`, `ST_PARITY` and `ST_STOP`. Its transitions are:
- idle-to-start, taken on a tick while the holding stage is full;
- start-to-data, after sixteen ticks;
- data-to-data, for each further bit;
- data-to-parity or data-to-stop, after the last data bit, depending on whether parity is enabled;
- parity-to-stop, after sixteen ticks;
- stop-to-start, taken when another byte is already waiting at the last stop tick;
- stop-to-idle, taken otherwise.

Top module: `uart_tx_core`

## Requirements
- R1: When no frame is in progress and break is off, `txd` is 1. A frame begins with a start cell in which `txd` is 0 for 16 ticks.
- R2: After the start cell, the data bits are sent least significant bit first, 16 ticks each. The number of data bits is 5 + `line_ctrl[1:0]`, so 00 gives 5 and 11 gives 8.
- R3: The stop time is at the high level. It is 16 ticks when `line_ctrl[2]`=0. When `line_ctrl[2]`=1, it is 24 ticks for a 5-bit word and 32 ticks for any longer word.
- R4: `line_ctrl[3]`=1 adds a 16-tick parity cell directly after the last data bit. With `line_ctrl[5]`=0, the cell carries even parity over the sent data bits when `line_ctrl[4]`=1, and odd parity when `line_ctrl[4]`=0.
- R5: With `line_ctrl[3]`=1 and `line_ctrl[5]`=1, the parity cell is fixed. It is 1 when `line_ctrl[4]`=0 (mark) and 0 when `line_ctrl[4]`=1 (space).
- R6: The tick fires once every `divisor` clock cycles. The first tick after reset comes on the `divisor`-th clock edge. A divisor of 0 behaves as 1.
- R7: `in_ready` and `hold_empty` are both 1 exactly when the holding stage is empty. A byte is taken on a clock edge where `in_valid` and `in_ready` are both 1.
- R8: `tx_empty` is 1 only when the holding stage is empty and no frame is in progress, that is, after the last stop tick has passed.
- R9: If a byte is waiting when the last stop tick arrives, its start cell begins on that same tick, with no idle time between the two frames.
- R10: While `line_ctrl[6]`=1, `txd` is 0. Frame timing keeps running underneath.
- R11: `line_ctrl[5:0]` is captured only when a frame starts. Changes made during a frame do not affect that frame.
- R12: During and after reset, `txd`=1, `in_ready`=1, `hold_empty`=1 and `tx_empty`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| divisor | input | DIV_W | Clock cycles per tick (0 treated as 1) |
| line_ctrl | input | 7 | Frame format and break control |
| in_data | input | 8 | Byte to send |
| in_valid | input | 1 | `in_data` is offered |
| in_ready | output | 1 | Holding stage can take a byte |
| txd | output | 1 | Serial line, high when idle |
| hold_empty | output | 1 | Holding stage is empty |
| tx_empty | output | 1 | Holding stage and frame engine are both idle |

## Verification
Several properties are checked on every cycle:
- the line stays high whenever the transmitter is empty and break is off;
- break holds the line low;
- an accepted byte fills the holding stage;
- `tx_empty` never rises while a byte is still held;
- a unity divisor ticks on every cycle;
- the captured format stays frozen between frame loads;
- the stop counter never passes its limit.

The bench's scenarios are needed to show the exact bit order and the correct parity value for each mode. They also show the 24-tick and 32-tick stop lengths, frames sent back to back with no gap, and that a format change made in the middle of a frame has no effect. A reference model written from the requirements predicts `txd` and the flags on every cycle.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP
    } tx_state_e;

    // frame shape captured when a frame starts
    typedef struct packed {
        logic [1:0] wls;        // word length select, 5 + wls bits
        logic       par_en;     // parity cell present
        logic [7:0] stop_ticks; // high time after the last data/parity cell
    } frame_cfg_t;

endpackage

// File: rtl/uart_tx_baud.sv
module uart_tx_baud #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] divisor,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] eff_div;

    // zero divisor behaves as one
    assign eff_div = (divisor == '0) ? DIV_W'(1) : divisor;
    assign tick    = (cnt_q >= eff_div - DIV_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + DIV_W'(1);
        end
    end
endmodule

// File: rtl/uart_tx_parity.sv
module uart_tx_parity import uart_tx_pkg::*; (
    input  logic [BYTE_W-1:0] data,
    input  logic [1:0]        wls,
    input  logic              even_sel,
    input  logic              stick,
    output logic              par_bit
);
    logic [BYTE_W-1:0] masked;
    logic              ones_odd;

    // keep only the bits that the word length actually sends
    for (genvar i = 0; i < BYTE_W; i++) begin : g_mask
        assign masked[i] = data[i] & (i < (5 + int'(wls)));
    end

    assign ones_odd = ^masked;

    always_comb begin
        if (stick) begin
            par_bit = ~even_sel;
        end else if (even_sel) begin
            par_bit = ones_odd;
        end else begin
            par_bit = ~ones_odd;
        end
    end
endmodule

// File: rtl/uart_tx_fmt.sv
module uart_tx_fmt import uart_tx_pkg::*; #(
    parameter int OVS = 16
) (
    input  logic [5:0]        fmt,
    input  logic [BYTE_W-1:0] data,
    output frame_cfg_t        cfg,
    output logic              par_bit
);
    localparam logic [7:0] STOP_ONE  = 8'(OVS);
    localparam logic [7:0] STOP_HALF = 8'(OVS + OVS / 2);
    localparam logic [7:0] STOP_TWO  = 8'(2 * OVS);

    always_comb begin
        cfg.wls    = fmt[1:0];
        cfg.par_en = fmt[3];
        if (!fmt[2]) begin
            cfg.stop_ticks = STOP_ONE;
        end else if (fmt[1:0] == 2'b00) begin
            cfg.stop_ticks = STOP_HALF;
        end else begin
            cfg.stop_ticks = STOP_TWO;
        end
    end

    uart_tx_parity u_par (
        .data     (data),
        .wls      (fmt[1:0]),
        .even_sel (fmt[4]),
        .stick    (fmt[5]),
        .par_bit  (par_bit)
    );
endmodule

// File: rtl/uart_tx_core.sv
module uart_tx_core import uart_tx_pkg::*; #(
    parameter int DIV_W = 16,
    parameter int OVS   = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] divisor,
    input  logic [6:0]       line_ctrl,
    input  logic [7:0]       in_data,
    input  logic             in_valid,
    output logic             in_ready,
    output logic             txd,
    output logic             hold_empty,
    output logic             tx_empty
);
    localparam logic [7:0] CELL_LAST = 8'(OVS - 1);

    tx_state_e         state_q, state_d;
    logic [7:0]        tcnt_q, tcnt_d;
    logic [2:0]        bit_q, bit_d;
    logic [BYTE_W-1:0] shift_q, shift_d;
    logic              par_q, par_d;
    frame_cfg_t        cfg_q, cfg_d;
    logic [BYTE_W-1:0] hold_q;
    logic              hold_full_q;

    logic              tick;
    logic              frame_load;
    logic              accept;
    frame_cfg_t        cfg_new;
    logic              par_new;
    logic              line_raw;
    logic [2:0]        last_idx;

    uart_tx_baud #(.DIV_W(DIV_W)) u_baud (
        .clk     (clk),
        .rst_n   (rst_n),
        .divisor (divisor),
        .tick    (tick)
    );

    uart_tx_fmt #(.OVS(OVS)) u_fmt (
        .fmt     (line_ctrl[5:0]),
        .data    (hold_q),
        .cfg     (cfg_new),
        .par_bit (par_new)
    );

    assign accept   = in_valid && !hold_full_q;
    assign last_idx = 3'd4 + {1'b0, cfg_q.wls};

    // holding stage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q      <= '0;
            hold_full_q <= 1'b0;
        end else if (accept) begin
            hold_q      <= in_data;
            hold_full_q <= 1'b1;
        end else if (frame_load) begin
            hold_full_q <= 1'b0;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            tcnt_q  <= '0;
            bit_q   <= '0;
            shift_q <= '0;
            par_q   <= 1'b0;
            cfg_q   <= '0;
        end else begin
            state_q <= state_d;
            tcnt_q  <= tcnt_d;
            bit_q   <= bit_d;
            shift_q <= shift_d;
            par_q   <= par_d;
            cfg_q   <= cfg_d;
        end
    end

    // next state
    always_comb begin
        state_d    = state_q;
        tcnt_d     = tcnt_q;
        bit_d      = bit_q;
        shift_d    = shift_q;
        par_d      = par_q;
        cfg_d      = cfg_q;
        frame_load = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (tick && hold_full_q) begin
                    frame_load = 1'b1;
                end
            end
            ST_START: begin
                if (tick) begin
                    if (tcnt_q == CELL_LAST) begin
                        state_d = ST_DATA;
                        tcnt_d  = '0;
                        bit_d   = '0;
                    end else begin
                        tcnt_d = tcnt_q + 8'd1;
                    end
                end
            end
            ST_DATA: begin
                if (tick) begin
                    if (tcnt_q == CELL_LAST) begin
                        tcnt_d = '0;
                        if (bit_q == last_idx) begin
                            state_d = cfg_q.par_en ? ST_PARITY : ST_STOP;
                        end else begin
                            bit_d   = bit_q + 3'd1;
                            shift_d = {1'b0, shift_q[BYTE_W-1:1]};
                        end
                    end else begin
                        tcnt_d = tcnt_q + 8'd1;
                    end
                end
            end
            ST_PARITY: begin
                if (tick) begin
                    if (tcnt_q == CELL_LAST) begin
                        state_d = ST_STOP;
                        tcnt_d  = '0;
                    end else begin
                        tcnt_d = tcnt_q + 8'd1;
                    end
                end
            end
            ST_STOP: begin
                if (tick) begin
                    if (tcnt_q == cfg_q.stop_ticks - 8'd1) begin
                        tcnt_d = '0;
                        if (hold_full_q) begin
                            frame_load = 1'b1;
                        end else begin
                            state_d = ST_IDLE;
                        end
                    end else begin
                        tcnt_d = tcnt_q + 8'd1;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
        if (frame_load) begin
            state_d = ST_START;
            tcnt_d  = '0;
            bit_d   = '0;
            shift_d = hold_q;
            cfg_d   = cfg_new;
            par_d   = par_new;
        end
    end

    // outputs
    always_comb begin
        unique case (state_q)
            ST_IDLE:   line_raw = 1'b1;
            ST_START:  line_raw = 1'b0;
            ST_DATA:   line_raw = shift_q[0];
            ST_PARITY: line_raw = par_q;
            ST_STOP:   line_raw = 1'b1;
            default:   line_raw = 1'b1;
        endcase
        txd        = line_raw & ~line_ctrl[6];
        in_ready   = !hold_full_q;
        hold_empty = !hold_full_q;
        tx_empty   = (state_q == ST_IDLE) && !hold_full_q;
    end
endmodule

// File: rtl/uart_tx_checker.sv
module uart_tx_checker import uart_tx_pkg::*; #(
    parameter int DIV_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [DIV_W-1:0] divisor,
    input logic [6:0]       line_ctrl,
    input logic             in_valid,
    input logic             in_ready,
    input logic             txd,
    input logic             hold_empty,
    input logic             tx_empty,
    input logic             tick,
    input logic             frame_load,
    input frame_cfg_t       cfg_q,
    input tx_state_e        state_q,
    input logic [7:0]       tcnt_q
);
    p_idle_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_empty && !line_ctrl[6]) |-> txd);

    p_stop_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STOP) |-> (tcnt_q < cfg_q.stop_ticks));

    p_unity_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (divisor <= DIV_W'(1)) |-> tick);

    p_accept_fills_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !hold_empty);

    p_empty_needs_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tx_empty |-> hold_empty);

    p_load_starts_r9: assert property (@(posedge clk) disable iff (!rst_n)
        frame_load |=> (state_q == ST_START));

    p_break_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
        line_ctrl[6] |-> !txd);

    p_cfg_frozen_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_load |=> $stable(cfg_q));
endmodule

bind uart_tx_core uart_tx_checker #(.DIV_W(DIV_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .divisor    (divisor),
    .line_ctrl  (line_ctrl),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .txd        (txd),
    .hold_empty (hold_empty),
    .tx_empty   (tx_empty),
    .tick       (tick),
    .frame_load (frame_load),
    .cfg_q      (cfg_q),
    .state_q    (state_q),
    .tcnt_q     (tcnt_q)
);

// File: tb/uart_tx_core_tb.sv
module uart_tx_core_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] divisor = 16'd1;
    logic [6:0]  line_ctrl = 7'h03;
    logic [7:0]  in_data = 8'h00;
    logic        in_valid = 1'b0;
    logic        in_ready, txd, hold_empty, tx_empty;

    int n_checks = 0;
    int n_fail = 0;
    string scen = "R12";

    always #4 clk = ~clk;

    uart_tx_core u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .divisor    (divisor),
        .line_ctrl  (line_ctrl),
        .in_data    (in_data),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .txd        (txd),
        .hold_empty (hold_empty),
        .tx_empty   (tx_empty)
    );

    // reference model: one queue entry per tick, value = line bit + 2*tag
    string tag_name [6] = '{"R1", "R2", "R3", "R4", "R5", "R9"};
    int    m_q[$];
    int    m_left;
    bit    m_hold_full;
    logic [7:0] m_hold;

    function automatic int eff_div(input logic [15:0] d);
        return (d == 0) ? 1 : int'(d);
    endfunction

    task automatic push_cell(input bit v, input int tag, input int ticks);
        for (int k = 0; k < ticks; k++) m_q.push_back(int'(v) + 2 * tag);
    endtask

    task automatic build_frame(input logic [7:0] b, input logic [6:0] lc, input bit chained);
        int  nb;
        int  ones;
        bit  p;
        nb = 5 + int'(lc[1:0]);
        push_cell(1'b0, chained ? 5 : 0, 16);
        ones = 0;
        for (int i = 0; i < nb; i++) begin
            push_cell(b[i], 1, 16);
            ones += int'(b[i]);
        end
        if (lc[3]) begin
            if (lc[5]) begin
                p = !lc[4];
                push_cell(p, 4, 16);
            end else begin
                p = lc[4] ? (ones % 2 == 1) : (ones % 2 == 0);
                push_cell(p, 3, 16);
            end
        end
        if (!lc[2]) push_cell(1'b1, 2, 16);
        else if (nb == 5) push_cell(1'b1, 2, 24);
        else push_cell(1'b1, 2, 32);
    endtask

    task automatic check(input string req, input logic act, input logic exp, input string what);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s [%s] %s actual=%b expected=%b at %0t", req, scen, what, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        bit tk;
        bit old_full;
        bit was_busy;
        logic exp_line;
        string req;
        if (!rst_n) begin
            m_q.delete();
            m_left = eff_div(divisor);
            m_hold_full = 1'b0;
        end else begin
            tk = (m_left <= 1);
            m_left = tk ? eff_div(divisor) : m_left - 1;
            old_full = m_hold_full;
            if (tk) begin
                was_busy = (m_q.size() > 0);
                if (was_busy) void'(m_q.pop_front());
                if (m_q.size() == 0 && old_full) begin
                    build_frame(m_hold, line_ctrl, was_busy);
                    m_hold_full = 1'b0;
                end
            end
            if (in_valid && !old_full) begin
                m_hold = in_data;
                m_hold_full = 1'b1;
            end
        end
        #2;
        if (line_ctrl[6]) begin
            exp_line = 1'b0;
            req = "R10";
        end else if (m_q.size() > 0) begin
            exp_line = m_q[0][0];
            req = tag_name[m_q[0] / 2];
        end else begin
            exp_line = 1'b1;
            req = "R1";
        end
        check(req, txd, exp_line, "txd");
        check("R7", in_ready, !m_hold_full, "in_ready");
        check("R7", hold_empty, !m_hold_full, "hold_empty");
        check("R8", tx_empty, (m_q.size() == 0) && !m_hold_full, "tx_empty");
    end

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic send(input logic [7:0] b);
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        in_valid = 1'b1;
        in_data  = b;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (!tx_empty) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog run did not complete actual=hung expected=done");
        summary();
    end

    initial begin
        int low_cnt;
        // R12: reset state
        @(negedge clk);
        check("R12", txd, 1'b1, "txd in reset");
        check("R12", tx_empty, 1'b1, "tx_empty in reset");
        do_reset();
        check("R12", in_ready, 1'b1, "in_ready after reset");
        check("R12", hold_empty, 1'b1, "hold_empty after reset");

        scen = "R2 8 bits";          line_ctrl = 7'h03; send(8'hAD); wait_idle();
        scen = "R3 5 bits 1.5 stop"; line_ctrl = 7'h04; send(8'h15); wait_idle();
        scen = "R4 7 bits even 2 stop"; line_ctrl = 7'h1E; send(8'h5A); wait_idle();
        scen = "R4 6 bits odd";      line_ctrl = 7'h09; send(8'h3C); wait_idle();
        scen = "R5 mark";            line_ctrl = 7'h2B; send(8'h81); wait_idle();
        scen = "R5 space";           line_ctrl = 7'h3B; send(8'h7F); wait_idle();

        scen = "R9 back to back";    line_ctrl = 7'h03;
        send(8'hC3); send(8'h3C); send(8'hF0); wait_idle();

        scen = "R11 mid-frame format change"; line_ctrl = 7'h03;
        send(8'h96);
        repeat (40) @(negedge clk);
        line_ctrl = 7'h1C;
        wait_idle();
        line_ctrl = 7'h03;

        scen = "R10 break idle";     line_ctrl = 7'h43; repeat (30) @(negedge clk);
        line_ctrl = 7'h03;
        scen = "R10 break in frame"; send(8'hA5);
        repeat (50) @(negedge clk);
        line_ctrl = 7'h43; repeat (40) @(negedge clk);
        line_ctrl = 7'h03; wait_idle();

        // R6: divisor 3 gives a 48-cycle start cell
        scen = "R6 divisor 3"; divisor = 16'd3; do_reset();
        send(8'h01);
        while (txd) @(negedge clk);
        low_cnt = 0;
        while (!txd && low_cnt < 200) begin
            low_cnt++;
            @(negedge clk);
        end
        n_checks++;
        if (low_cnt != 48) begin
            n_fail++;
            $display("FAIL R6 start cell length actual=%0d expected=48", low_cnt);
        end
        wait_idle();

        scen = "R6 divisor 0"; divisor = 16'd0; do_reset();
        line_ctrl = 7'h0F; send(8'h2E); wait_idle();

        summary();
    end
endmodule